// File: doc/BRIEF.md
# Root Hub Downstream Port Control Register Bank

This block keeps the control and status state for the downstream ports of a USB host controller's root hub, plus a hub-wide power register. Software drives it through a plain register bus: a word address, 32-bit write data, a write strobe and combinational read data. Word 0 is the hub register. Words 1 to NPORTS are the port registers, one per port.

Port registers take write commands rather than stored values. A 1 in a command bit position sets or clears one port condition. A 1 in a change-flag position clears that flag. A 0 anywhere does nothing. A read returns the live port status in the low half-word and the sticky change flags in the high half-word, so a read never echoes the last write.

Each port also follows two inputs, device-present and overcurrent, and drives four outputs: power, enable, suspend and bus reset. The block times a port reset itself, using a clock-rate parameter and a duration parameter.

Top module: `usbrh_port_bank`

## Requirements
- R1: After reset, every port output is 0, every port register reads 0, and the hub register reads only its power-good field.
- R2: In a port register, writing 1 to bit 1 enables a powered, connected port that is not resetting. Writing 1 to bit 0 disables it. If both bits are set in one write, the port ends disabled.
- R3: Writing 1 to bit 1 while no device is present leaves enable at 0 and sets the connect change flag (bit 16).
- R4: Writing 1 to bit 2 suspends the port, but only while it is enabled. Writing 1 to bit 3 clears suspend and sets the suspend change flag (bit 18). Disabling the port also clears suspend.
- R5: Writing 1 to bit 8 powers the port on. Writing 1 to bit 9 powers it off, and off wins if both bits are set. Losing power clears enable, suspend and any reset in progress. While the port is unpowered, enable, suspend and reset commands have no effect.
- R6: Writing 1 to bit 4 on a powered, connected port holds the reset output (status bit 4) high for CLK_KHZ*RESET_MS clock cycles. When the reset ends, the block clears reset, sets enable and sets the reset-complete change flag (bit 20).
- R7: The change flags at bits 16 to 20 (connect, enable, suspend, overcurrent, reset) are cleared only by writing 1 to their own bit. Writing 0 has no effect.
- R8: A port read returns connect at bit 0, enable at bit 1, suspend at bit 2, overcurrent at bit 3, reset at bit 4, power at bit 8, and the change flags at bits 16 to 20. All other bits read 0.
- R9: Any edge of the connect input sets the connect change flag. A falling edge also clears enable and suspend and aborts a reset in progress.
- R10: A rising overcurrent input sets overcurrent status (bit 3) and its change flag (bit 19), and removes port power. If the port was enabled, the enable change flag (bit 17) is also set. While the input stays high, power-on commands are ignored.
- R11: In the hub register, writing 1 to bit 16 powers on every port that is not in overcurrent. Writing 1 to bit 0 powers all ports off, and off wins if both bits are set. A hub read returns PWRGOOD_MS/2 (2 ms units) in bits 31:24 and, at bit 0, a 1 when any port is powered.
- R12: A write to an address above NPORTS changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Word address (0 = hub, 1..NPORTS = ports) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| dev_present | input | NPORTS | Per-port device connect level |
| ovr_current | input | NPORTS | Per-port overcurrent level |
| port_power | output | NPORTS | Per-port power switch |
| port_enable | output | NPORTS | Per-port enabled state |
| port_suspend | output | NPORTS | Per-port suspended state |
| port_reset | output | NPORTS | Per-port bus reset in progress |

## Verification
All port state is registered, and each state bit is also a read bit or an output pin. A wrong set/clear priority or a change flag that sets wrongly therefore shows on reg_rdata and on the pins one clock edge after the write or input edge that caused it. A reset timer that runs one cycle long or short shows only at the end of the window, when port_reset falls and enable plus the reset-complete flag rise. For that reason the bench samples the cycle before and the cycle of that edge. An abort that leaks through shows as enable or the reset-complete flag set after a disconnect.

// File: rtl/usbrh_pkg.sv
package usbrh_pkg;

   // command bit positions in a port write
   localparam int CMD_EN_CLR   = 0;
   localparam int CMD_EN_SET   = 1;
   localparam int CMD_SUSP_SET = 2;
   localparam int CMD_SUSP_CLR = 3;
   localparam int CMD_RST_GO   = 4;
   localparam int CMD_PWR_ON   = 8;
   localparam int CMD_PWR_OFF  = 9;

   // change flags occupy the upper half-word
   localparam int CHG_LSB  = 16;
   localparam int CHG_N    = 5;
   localparam int CHG_CONN = 0;
   localparam int CHG_EN   = 1;
   localparam int CHG_SUSP = 2;
   localparam int CHG_OC   = 3;
   localparam int CHG_RST  = 4;

   // hub register bit positions
   localparam int HUB_OFF    = 0;
   localparam int HUB_ON     = 16;
   localparam int HUB_PG_LSB = 24;

   typedef struct packed {
      logic pwr;
      logic rst;
      logic oc;
      logic susp;
      logic en;
      logic conn;
   } port_state_t;

   function automatic logic [31:0] pack_port(port_state_t s, logic [CHG_N-1:0] c);
      logic [31:0] w;
      w = '0;
      w[0] = s.conn;
      w[1] = s.en;
      w[2] = s.susp;
      w[3] = s.oc;
      w[4] = s.rst;
      w[8] = s.pwr;
      w[CHG_LSB +: CHG_N] = c;
      return w;
   endfunction

endpackage

// File: rtl/usbrh_rst_timer.sv
module usbrh_rst_timer #(
   parameter int CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("usbrh_rst_timer: CYCLES must be at least 1");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end else if (abort_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0) && !abort_i && !start_i;

   assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD);
   assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_q);
   assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && !start_i) |=> !busy_q);

endmodule

// File: rtl/usbrh_port.sv
module usbrh_port
   import usbrh_pkg::*;
#(
   parameter int RST_CYCLES = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [31:0] wd_i,
   input  logic        gang_on_i,
   input  logic        gang_off_i,
   input  logic        conn_in,
   input  logic        oc_in,
   output logic [31:0] rd_o,
   output logic        pwr_o,
   output logic        en_o,
   output logic        susp_o,
   output logic        rst_o
);
   logic conn_q, oc_q, pwr_q, en_q, susp_q;
   logic [CHG_N-1:0] chg_q;

   logic conn_rise, conn_fall, oc_rise;
   logic pwr_cut, pwr_nx, drop;
   logic en_nx, susp_nx;
   logic tmr_start, tmr_busy, tmr_done;
   logic [CHG_N-1:0] chg_set, chg_clr;
   logic unused_wd;

   assign unused_wd = ^{wd_i[31:CHG_LSB+CHG_N], wd_i[15:10], wd_i[7:5]};

   always_comb begin
      conn_rise = conn_in & ~conn_q;
      conn_fall = conn_q & ~conn_in;
      oc_rise   = oc_in & ~oc_q;

      pwr_cut = (wr_i & wd_i[CMD_PWR_OFF]) | gang_off_i | oc_in;
      if (pwr_cut)                               pwr_nx = 1'b0;
      else if ((wr_i & wd_i[CMD_PWR_ON]) | gang_on_i) pwr_nx = 1'b1;
      else                                       pwr_nx = pwr_q;

      drop = conn_fall | ~pwr_nx;

      tmr_start = wr_i & wd_i[CMD_RST_GO] & conn_q & pwr_q & ~drop;

      if (drop)                         en_nx = 1'b0;
      else if (tmr_done)                en_nx = 1'b1;
      else if (wr_i & wd_i[CMD_EN_CLR]) en_nx = 1'b0;
      else if (wr_i & wd_i[CMD_EN_SET] & conn_q & pwr_q & ~tmr_busy)
                                        en_nx = 1'b1;
      else                              en_nx = en_q;

      if (drop)                                          susp_nx = 1'b0;
      else if (wr_i & (wd_i[CMD_SUSP_CLR] | wd_i[CMD_EN_CLR])) susp_nx = 1'b0;
      else if (wr_i & wd_i[CMD_SUSP_SET] & en_q)         susp_nx = 1'b1;
      else                                               susp_nx = susp_q;

      chg_set            = '0;
      chg_set[CHG_CONN]  = conn_rise | conn_fall | (wr_i & wd_i[CMD_EN_SET] & ~conn_q);
      chg_set[CHG_EN]    = en_q & oc_in;
      chg_set[CHG_SUSP]  = wr_i & wd_i[CMD_SUSP_CLR] & susp_q & ~drop;
      chg_set[CHG_OC]    = oc_rise;
      chg_set[CHG_RST]   = tmr_done;

      chg_clr = wr_i ? wd_i[CHG_LSB +: CHG_N] : '0;
   end

   usbrh_rst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tmr_start),
      .abort_i (drop),
      .busy_o  (tmr_busy),
      .done_o  (tmr_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_q <= 1'b0;
         oc_q   <= 1'b0;
         pwr_q  <= 1'b0;
         en_q   <= 1'b0;
         susp_q <= 1'b0;
         chg_q  <= '0;
      end else begin
         conn_q <= conn_in;
         oc_q   <= oc_in;
         pwr_q  <= pwr_nx;
         en_q   <= en_nx;
         susp_q <= susp_nx;
         chg_q  <= (chg_q & ~chg_clr) | chg_set;
      end
   end

   port_state_t st;
   always_comb begin
      st.conn = conn_q;
      st.en   = en_q;
      st.susp = susp_q;
      st.oc   = oc_q;
      st.rst  = tmr_busy;
      st.pwr  = pwr_q;
   end

   assign rd_o   = pack_port(st, chg_q);
   assign pwr_o  = pwr_q;
   assign en_o   = en_q;
   assign susp_o = susp_q;
   assign rst_o  = tmr_busy;

   assert_en_needs_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> pwr_q);
   assert_susp_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      susp_q |-> en_q);
   assert_rst_end_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_done |=> (en_q && chg_q[CHG_RST]));
   assert_chg_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ((chg_q & $past(chg_q)) == $past(chg_q)));
   assert_unplug_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conn_fall |=> (!en_q && !susp_q && !tmr_busy && chg_q[CHG_CONN]));
   assert_oc_cuts_pwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oc_in |=> (!pwr_q && oc_q));

endmodule

// File: rtl/usbrh_hub_ctl.sv
module usbrh_hub_ctl
   import usbrh_pkg::*;
#(
   parameter int NPORTS     = 4,
   parameter int PWRGOOD_MS = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [31:0]       wd_i,
   input  logic [NPORTS-1:0] pwr_i,
   output logic              gang_on_o,
   output logic              gang_off_o,
   output logic [31:0]       rd_o
);
   localparam int PG_UNITS = PWRGOOD_MS / 2;
   localparam logic [7:0] PG_FIELD = 8'(PG_UNITS);

   if (PG_UNITS > 255) begin : g_bad_pg
      $error("usbrh_hub_ctl: PWRGOOD_MS/2 must fit in 8 bits");
   end

   logic unused_wd;
   assign unused_wd = ^{wd_i[31:HUB_ON+1], wd_i[HUB_ON-1:HUB_OFF+1]};

   assign gang_off_o = wr_i & wd_i[HUB_OFF];
   assign gang_on_o  = wr_i & wd_i[HUB_ON] & ~wd_i[HUB_OFF];

   always_comb begin
      rd_o = '0;
      rd_o[HUB_PG_LSB +: 8] = PG_FIELD;
      rd_o[HUB_OFF]         = |pwr_i;
   end

   assert_gang_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(gang_on_o && gang_off_o));
   assert_gang_off_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
      gang_off_o |=> (pwr_i == '0));

endmodule

// File: rtl/usbrh_port_bank.sv
module usbrh_port_bank
   import usbrh_pkg::*;
#(
   parameter int NPORTS     = 4,
   parameter int ADDR_W     = 4,
   parameter int CLK_KHZ    = 48000,
   parameter int RESET_MS   = 10,
   parameter int PWRGOOD_MS = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NPORTS-1:0] dev_present,
   input  logic [NPORTS-1:0] ovr_current,
   output logic [NPORTS-1:0] port_power,
   output logic [NPORTS-1:0] port_enable,
   output logic [NPORTS-1:0] port_suspend,
   output logic [NPORTS-1:0] port_reset
);
   localparam int RST_CYCLES = CLK_KHZ * RESET_MS;

   if (NPORTS < 1 || NPORTS > 15) begin : g_bad_nports
      $error("usbrh_port_bank: NPORTS must be 1..15");
   end
   if ((2 ** ADDR_W) <= NPORTS) begin : g_bad_addr
      $error("usbrh_port_bank: ADDR_W too narrow for NPORTS");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("usbrh_port_bank: reset window must be at least one cycle");
   end

   logic              hub_wr, gang_on, gang_off;
   logic [31:0]       hub_rd;
   logic [NPORTS-1:0] port_wr;
   logic [31:0]       port_rd [NPORTS];

   assign hub_wr = reg_we && (reg_addr == '0);

   usbrh_hub_ctl #(.NPORTS(NPORTS), .PWRGOOD_MS(PWRGOOD_MS)) u_hub (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (hub_wr),
      .wd_i       (reg_wdata),
      .pwr_i      (port_power),
      .gang_on_o  (gang_on),
      .gang_off_o (gang_off),
      .rd_o       (hub_rd)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign port_wr[p] = reg_we && (reg_addr == ADDR_W'(p + 1));

      usbrh_port #(.RST_CYCLES(RST_CYCLES)) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_i       (port_wr[p]),
         .wd_i       (reg_wdata),
         .gang_on_i  (gang_on),
         .gang_off_i (gang_off),
         .conn_in    (dev_present[p]),
         .oc_in      (ovr_current[p]),
         .rd_o       (port_rd[p]),
         .pwr_o      (port_power[p]),
         .en_o       (port_enable[p]),
         .susp_o     (port_suspend[p]),
         .rst_o      (port_reset[p])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == '0) reg_rdata = hub_rd;
      for (int p = 0; p < NPORTS; p++) begin
         if (reg_addr == ADDR_W'(p + 1)) reg_rdata = port_rd[p];
      end
   end

   assert_unmapped_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_addr) > NPORTS) |-> (reg_rdata == '0));
   assert_unmapped_write_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_addr) > NPORTS && !gang_on && !gang_off && ovr_current == '0
       && dev_present == $past(dev_present)) |=> (port_power == $past(port_power)));

endmodule

// File: tb/sim_usbrh_port_bank.sv
module sim_usbrh_port_bank;
   localparam int NP   = 2;
   localparam int AW   = 4;
   localparam int KHZ  = 2;
   localparam int RMS  = 5;
   localparam int PGMS = 40;
   localparam int RCYC = KHZ * RMS;
   localparam logic [31:0] HUB_BASE = 32'h1400_0000;   // 40 ms / 2 = 20 in bits 31:24

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NP-1:0] dev_present = '0;
   logic [NP-1:0] ovr_current = '0;
   logic [NP-1:0] port_power, port_enable, port_suspend, port_reset;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   usbrh_port_bank #(.NPORTS(NP), .ADDR_W(AW), .CLK_KHZ(KHZ), .RESET_MS(RMS),
                     .PWRGOOD_MS(PGMS)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_present(dev_present),
      .ovr_current(ovr_current), .port_power(port_power), .port_enable(port_enable),
      .port_suspend(port_suspend), .port_reset(port_reset));

   // port-1 vector table: inputs for one cycle, optional write, expected read after the edge
   localparam int NV = 24;
   localparam bit V_CONN [NV] = '{0,1,1,1,1,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1,1,1};
   localparam bit V_OC   [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,1,1,0,0};
   localparam bit V_WE   [NV] = '{1,0,1,1,1,1,1,1,1,1,0,1,1,1,0,1,1,1,1,1,0,1,0,1};
   localparam logic [31:0] V_WD [NV] = '{
      32'h0000_0100,  // R5 power on
      32'h0,          // R9 plug in
      32'h0001_0000,  // R7 clear connect change
      32'h0000_0000,  // R7 zero write
      32'h0000_0002,  // R2 enable
      32'h0000_0004,  // R4 suspend
      32'h0000_0008,  // R4 resume
      32'h0004_0000,  // R7 clear suspend change
      32'h0000_0003,  // R2 set+clear together
      32'h0000_0002,  // R2 enable again
      32'h0,          // R9 unplug
      32'h0001_0000,  // R7 clear
      32'h0000_0002,  // R3 enable with no device
      32'h0001_0000,  // R7 clear
      32'h0,          // R9 plug in
      32'h0001_0000,  // R7 clear
      32'h0000_0004,  // R4 suspend while disabled
      32'h0000_0300,  // R5 on+off together
      32'h0000_0002,  // R5 enable while unpowered
      32'h0000_0100,  // R5 power on
      32'h0,          // R10 overcurrent
      32'h0000_0100,  // R10 power on during overcurrent
      32'h0,          // R10 overcurrent gone
      32'h0008_0000   // R7 clear overcurrent change
   };
   localparam logic [31:0] V_EXP [NV] = '{
      32'h0000_0100, 32'h0001_0101, 32'h0000_0101, 32'h0000_0101,
      32'h0000_0103, 32'h0000_0107, 32'h0004_0103, 32'h0000_0103,
      32'h0000_0101, 32'h0000_0103, 32'h0001_0100, 32'h0000_0100,
      32'h0001_0100, 32'h0000_0100, 32'h0001_0101, 32'h0000_0101,
      32'h0000_0101, 32'h0000_0001, 32'h0000_0001, 32'h0000_0101,
      32'h0008_0009, 32'h0008_0009, 32'h0008_0001, 32'h0000_0001
   };
   localparam int V_REQ [NV] = '{5,9,7,7,2,4,4,7,2,2,9,7,3,7,9,7,4,5,5,5,10,10,10,7};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1, r); check("R1 port1", r, 32'h0);
      rd(2, r); check("R1 port2", r, 32'h0);
      rd(0, r); check("R1 hub", r, HUB_BASE);
      check("R1 pins", {port_power, port_enable, port_suspend, port_reset}, '0);

      // table walk on port 1
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         dev_present[0] = V_CONN[i];
         ovr_current[0] = V_OC[i];
         reg_addr = 1; reg_wdata = V_WD[i]; reg_we = V_WE[i];
         @(negedge clk);
         reg_we = 1'b0; reg_wdata = '0;
         rd(1, r);
         check($sformatf("R%0d row %0d", V_REQ[i], i), r, V_EXP[i]);
         check($sformatf("R%0d row %0d pins", V_REQ[i], i),
               {31'b0, port_enable[0]}, {31'b0, V_EXP[i][1]});
      end
      check("R8 port1 pin power", {31'b0, port_power[0]}, {31'b0, V_EXP[NV-1][8]});

      // R11 gang power on
      wr(0, 32'h0001_0000);
      check("R11 gang on", {30'b0, port_power}, 32'h3);
      rd(0, r); check("R11 hub read", r, HUB_BASE | 32'h1);

      // R6 port reset on port 2
      @(negedge clk); dev_present[1] = 1'b1;
      @(negedge clk);
      wr(2, 32'h0001_0000);
      wr(2, 32'h0000_0010);
      check("R6 reset starts", {31'b0, port_reset[1]}, 32'h1);
      repeat (RCYC - 1) @(negedge clk);
      check("R6 reset held", {31'b0, port_reset[1]}, 32'h1);
      check("R6 not yet enabled", {31'b0, port_enable[1]}, 32'h0);
      @(negedge clk);
      check("R6 reset ends", {31'b0, port_reset[1]}, 32'h0);
      rd(2, r); check("R6 read after reset", r, 32'h0010_0103);
      wr(2, 32'h0010_0000);
      rd(2, r); check("R7 reset change cleared", r, 32'h0000_0103);

      // R9 unplug aborts a reset in progress
      wr(2, 32'h0000_0010);
      @(negedge clk);
      dev_present[1] = 1'b0;
      @(negedge clk);
      check("R9 reset aborted", {31'b0, port_reset[1]}, 32'h0);
      rd(2, r); check("R9 unplug during reset", r, 32'h0001_0100);
      repeat (RCYC + 2) @(negedge clk);
      rd(2, r); check("R9 no late completion", r, 32'h0001_0100);

      // R10 overcurrent while enabled
      dev_present[1] = 1'b1;
      @(negedge clk);
      wr(2, 32'h0001_0000);
      wr(2, 32'h0000_0002);
      check("R2 port2 enabled", {31'b0, port_enable[1]}, 32'h1);
      @(negedge clk); ovr_current[1] = 1'b1;
      @(negedge clk);
      rd(2, r); check("R10 overcurrent while enabled", r, 32'h000A_0009);
      wr(0, 32'h0001_0000);
      check("R11 gang on skips overcurrent", {30'b0, port_power}, 32'h1);

      // R11 gang off with both bits
      wr(0, 32'h0001_0001);
      check("R11 gang off wins", {30'b0, port_power}, 32'h0);
      rd(0, r); check("R11 hub read off", r, HUB_BASE);

      // R12 unmapped address
      ovr_current[1] = 1'b0;
      @(negedge clk);
      wr(5, 32'h0000_0100);
      check("R12 unmapped write", {30'b0, port_power}, 32'h0);
      rd(5, r); check("R12 unmapped read", r, 32'h0);

      finish_run();
   end
endmodule